// File: doc/BRIEF.md
# Two-Input Occupancy-Arbitrated Packet Merger

This block joins two byte-wide datagram streams onto a single byte-wide output. One input carries ring traffic passing through; the other carries traffic produced locally. The senders never wait, so each input has its own FIFO and accepts a byte on every cycle. A packet is a START code (0x01), any number of payload bytes, and a STOP code (0x40). Between packets the line carries IDLE (0x00). Payload bytes must not take any of these three code values.

Each FIFO runs a write state machine with states OUTSIDE, INSIDE and SKIP. The OUTSIDE to INSIDE transition happens on an accepted START. INSIDE returns to OUTSIDE on a stored STOP, and it falls to SKIP when the FIFO overflows mid-packet. SKIP returns to OUTSIDE on a STOP. An arbiter state machine with states WAIT, SEND_THRU and SEND_LOCAL picks a queue only in WAIT. The transition WAIT to SEND_THRU or WAIT to SEND_LOCAL happens on a grant. A send state returns to WAIT once it has forwarded a STOP. A queue is a candidate only when it holds at least one complete packet. The fuller candidate wins, and the pass-through input wins a tie. Each FIFO reports its fill level, the peak fill level since reset and a saturating count of packets lost to overflow, for congestion studies.

Top module: `pkt_merge2`

## Requirements
- R1: After reset the output is IDLE (0x00), and every level, peak and drop count is zero.
- R2: The block never stores an IDLE byte. It discards payload bytes and STOP bytes that arrive outside a packet (before any START), so they change no level and produce no output.
- R3: Every packet stored from START to STOP leaves the block whole, with the same bytes in the same order. A START arriving inside an open packet throws away that partial packet and begins a new one.
- R4: A queue with no stored STOP is never served. An unfinished packet stays in its FIFO and the output stays IDLE.
- R5: When a grant is made, and both queues hold a complete packet, the queue with the larger fill level is served first.
- R6: When both queues hold a complete packet and their fill levels are equal, the pass-through queue is served first.
- R7: Once a START is forwarded, the same queue is drained until its STOP, so packets never interleave. A START on the output follows only an IDLE or a STOP.
- R8: The output carries IDLE on every cycle in which no packet is being forwarded.
- R9: The drop path works on a FIFO that holds DEPTH bytes at the start of a cycle. If a START, or a byte of an open packet, arrives at such a FIFO, the bytes of the partial packet are removed and its drop count rises by one. Later bytes up to and including the next STOP are discarded.
- R10: The drop count saturates at its maximum value (2^DROP_W - 1) and never wraps.
- R11: The level output gives the number of bytes stored. The peak output gives the largest level seen since reset and never decreases.
- R12: A level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thru_byte | input | 8 | Pass-through input byte, one per cycle |
| local_byte | input | 8 | Local input byte, one per cycle |
| out_byte | output | 8 | Merged output byte (registered) |
| thru_level | output | $clog2(DEPTH)+1 | Bytes held in the pass-through FIFO |
| local_level | output | $clog2(DEPTH)+1 | Bytes held in the local FIFO |
| thru_peak | output | $clog2(DEPTH)+1 | Highest pass-through level since reset |
| local_peak | output | $clog2(DEPTH)+1 | Highest local level since reset |
| thru_drops | output | DROP_W | Saturating pass-through overflow count |
| local_drops | output | DROP_W | Saturating local overflow count |

## Verification
The bench lines up the STOP bytes of two packets of different lengths on the same cycle, and then does the same with two packets of equal length. An arbiter that ignored fill level or broke ties toward the local side would emit the packets in the wrong order. It also completes a short pass-through packet while a long local packet is draining. A merger without packet-boundary locking would splice the short packet into the long one. It fills a FIFO to DEPTH inside one packet and then pushes one more byte. A design that left the partial packet behind would later send a headless fragment, and one that counted the trailing bytes would show too many drops. Repeated overflows drive the drop count past its maximum, which catches a counter that wraps instead of saturating.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam logic [7:0] CODE_IDLE  = 8'h00;
    localparam logic [7:0] CODE_START = 8'h01;
    localparam logic [7:0] CODE_STOP  = 8'h40;

    typedef enum logic [1:0] {W_OUTSIDE, W_INSIDE, W_SKIP} wr_state_t;
    typedef enum logic [1:0] {A_WAIT, A_SEND_THRU, A_SEND_LOCAL} arb_state_t;
endpackage

// File: rtl/pm_queue.sv
module pm_queue
    import pm_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DROP_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_byte,
    input  logic              pop,
    output logic [7:0]        head,
    output logic              has_pkt,
    output logic [LW-1:0]     level,
    output logic [LW-1:0]     peak,
    output logic [DROP_W-1:0] drops
);
    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] wr_ptr, rd_ptr, base_ptr, wr_addr;
    logic [LW-1:0] wr_nxt, rd_nxt, lvl_nxt;
    logic [LW-1:0] stop_cnt;
    wr_state_t     wst, wst_nxt;
    logic          wr_en, commit, drop_hit, full, pop_stop;

    assign level    = wr_ptr - rd_ptr;
    assign full     = (level == LW'(DEPTH));
    assign head     = mem[rd_ptr[AW-1:0]];
    assign has_pkt  = (stop_cnt != '0);
    assign pop_stop = pop && (head == CODE_STOP);
    assign rd_nxt   = pop ? rd_ptr + LW'(1) : rd_ptr;
    assign lvl_nxt  = wr_nxt - rd_nxt;

    always_comb begin
        wst_nxt  = wst;
        wr_en    = 1'b0;
        commit   = 1'b0;
        drop_hit = 1'b0;
        wr_addr  = wr_ptr;
        wr_nxt   = wr_ptr;
        unique case (wst)
            W_OUTSIDE: begin
                if (in_byte == CODE_START) begin
                    if (full) begin
                        drop_hit = 1'b1;
                        wst_nxt  = W_SKIP;
                    end else begin
                        wr_en   = 1'b1;
                        wr_nxt  = wr_ptr + LW'(1);
                        wst_nxt = W_INSIDE;
                    end
                end
            end
            W_INSIDE: begin
                if (in_byte == CODE_START) begin
                    wr_en   = 1'b1;
                    wr_addr = base_ptr;
                    wr_nxt  = base_ptr + LW'(1);
                end else if (in_byte != CODE_IDLE) begin
                    if (full) begin
                        drop_hit = 1'b1;
                        wr_nxt   = base_ptr;
                        wst_nxt  = (in_byte == CODE_STOP) ? W_OUTSIDE : W_SKIP;
                    end else begin
                        wr_en  = 1'b1;
                        wr_nxt = wr_ptr + LW'(1);
                        if (in_byte == CODE_STOP) begin
                            commit  = 1'b1;
                            wst_nxt = W_OUTSIDE;
                        end
                    end
                end
            end
            W_SKIP: begin
                if (in_byte == CODE_STOP) wst_nxt = W_OUTSIDE;
            end
            default: wst_nxt = W_OUTSIDE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr[AW-1:0]] <= in_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst      <= W_OUTSIDE;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            base_ptr <= '0;
            stop_cnt <= '0;
            peak     <= '0;
            drops    <= '0;
        end else begin
            wst    <= wst_nxt;
            wr_ptr <= wr_nxt;
            rd_ptr <= rd_nxt;
            if (wst == W_OUTSIDE && wr_en) base_ptr <= wr_ptr;
            unique case ({commit, pop_stop})
                2'b10:   stop_cnt <= stop_cnt + LW'(1);
                2'b01:   stop_cnt <= stop_cnt - LW'(1);
                default: stop_cnt <= stop_cnt;
            endcase
            if (lvl_nxt > peak) peak <= lvl_nxt;
            if (drop_hit && drops != '1) drops <= drops + DROP_W'(1);
        end
    end
endmodule

// File: rtl/pm_arbiter.sv
module pm_arbiter
    import pm_pkg::*;
#(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    has_pkt,
    input  logic [LW-1:0] lvl_thru,
    input  logic [LW-1:0] lvl_local,
    input  logic [7:0]    head_thru,
    input  logic [7:0]    head_local,
    output logic [1:0]    pop,
    output logic [7:0]    out_byte
);
    arb_state_t st, st_nxt;
    logic [7:0] out_nxt;

    always_comb begin
        st_nxt  = st;
        pop     = 2'b00;
        out_nxt = CODE_IDLE;
        unique case (st)
            A_WAIT: begin
                if (has_pkt[0] && (!has_pkt[1] || lvl_thru >= lvl_local)) begin
                    pop[0]  = 1'b1;
                    out_nxt = head_thru;
                    st_nxt  = A_SEND_THRU;
                end else if (has_pkt[1]) begin
                    pop[1]  = 1'b1;
                    out_nxt = head_local;
                    st_nxt  = A_SEND_LOCAL;
                end
            end
            A_SEND_THRU: begin
                pop[0]  = 1'b1;
                out_nxt = head_thru;
                if (head_thru == CODE_STOP) st_nxt = A_WAIT;
            end
            A_SEND_LOCAL: begin
                pop[1]  = 1'b1;
                out_nxt = head_local;
                if (head_local == CODE_STOP) st_nxt = A_WAIT;
            end
            default: st_nxt = A_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= A_WAIT;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_byte <= CODE_IDLE;
        else        out_byte <= out_nxt;
    end
endmodule

// File: rtl/pkt_merge2.sv
module pkt_merge2 #(
    parameter int DEPTH  = 256,
    parameter int DROP_W = 8,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        thru_byte,
    input  logic [7:0]        local_byte,
    output logic [7:0]        out_byte,
    output logic [LW-1:0]     thru_level,
    output logic [LW-1:0]     local_level,
    output logic [LW-1:0]     thru_peak,
    output logic [LW-1:0]     local_peak,
    output logic [DROP_W-1:0] thru_drops,
    output logic [DROP_W-1:0] local_drops
);
    logic [7:0]        in_b  [2];
    logic [7:0]        head  [2];
    logic [LW-1:0]     lvl   [2];
    logic [LW-1:0]     pk    [2];
    logic [DROP_W-1:0] dr    [2];
    logic [1:0]        has_pkt, pop;

    assign in_b[0] = thru_byte;
    assign in_b[1] = local_byte;

    for (genvar q = 0; q < 2; q++) begin : g_queue
        pm_queue #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_queue (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_byte (in_b[q]),
            .pop     (pop[q]),
            .head    (head[q]),
            .has_pkt (has_pkt[q]),
            .level   (lvl[q]),
            .peak    (pk[q]),
            .drops   (dr[q])
        );
    end

    pm_arbiter #(.LW(LW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .has_pkt    (has_pkt),
        .lvl_thru   (lvl[0]),
        .lvl_local  (lvl[1]),
        .head_thru  (head[0]),
        .head_local (head[1]),
        .pop        (pop),
        .out_byte   (out_byte)
    );

    assign thru_level  = lvl[0];
    assign local_level = lvl[1];
    assign thru_peak   = pk[0];
    assign local_peak  = pk[1];
    assign thru_drops  = dr[0];
    assign local_drops = dr[1];
endmodule

// File: rtl/pkt_merge2_chk.sv
module pkt_merge2_chk #(
    parameter int DEPTH  = 256,
    parameter int DROP_W = 8,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        out_byte,
    input logic [LW-1:0]     thru_level,
    input logic [LW-1:0]     local_level,
    input logic [LW-1:0]     thru_peak,
    input logic [LW-1:0]     local_peak,
    input logic [DROP_W-1:0] thru_drops,
    input logic [DROP_W-1:0] local_drops
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        thru_level <= LW'(DEPTH) && local_level <= LW'(DEPTH)); // R12
    AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        thru_peak >= thru_level && local_peak >= local_level); // R11
    AST_PEAK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> thru_peak >= $past(thru_peak) && local_peak >= $past(local_peak)); // R11
    AST_START_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_byte == 8'h01 |-> $past(out_byte) == 8'h00 || $past(out_byte) == 8'h40); // R7
    AST_DROP_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        thru_drops == '1 |=> thru_drops == '1); // R10
    AST_DROP_HOLDS_MAX_L: assert property (@(posedge clk) disable iff (!rst_n)
        local_drops == '1 |=> local_drops == '1); // R10
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> local_drops == $past(local_drops) || local_drops == $past(local_drops) + DROP_W'(1)); // R9
endmodule

bind pkt_merge2 pkt_merge2_chk #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_byte    (out_byte),
    .thru_level  (thru_level),
    .local_level (local_level),
    .thru_peak   (thru_peak),
    .local_peak  (local_peak),
    .thru_drops  (thru_drops),
    .local_drops (local_drops)
);

// File: tb/pkt_merge2_bench.sv
`timescale 1ns/1ps
module pkt_merge2_bench;
    localparam int DEPTH  = 256;
    localparam int DROP_W = 3;
    localparam int LW     = $clog2(DEPTH) + 1;
    localparam logic [7:0] ST = 8'h01, SP = 8'h40;
    // table entry: {source (0 thru, 1 local), payload length, seed}
    localparam int NV = 6;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'd1, 8'd3}, {1'b1, 8'd5, 8'd10}, {1'b0, 8'd12, 8'd20},
        {1'b1, 8'd0, 8'd0}, {1'b1, 8'd20, 8'd40}, {1'b0, 8'd3, 8'd50}};

    logic clk = 0, rst_n = 0;
    logic [7:0] thru_byte = 0, local_byte = 0, out_byte;
    logic [LW-1:0] thru_level, local_level, thru_peak, local_peak;
    logic [DROP_W-1:0] thru_drops, local_drops;
    int n_chk = 0, n_bad = 0;
    logic [7:0] got [$];
    logic [7:0] exp [$];

    always #5 clk = ~clk;

    pkt_merge2 #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_pkt_merge2 (
        .clk(clk), .rst_n(rst_n), .thru_byte(thru_byte), .local_byte(local_byte),
        .out_byte(out_byte), .thru_level(thru_level), .local_level(local_level),
        .thru_peak(thru_peak), .local_peak(local_peak),
        .thru_drops(thru_drops), .local_drops(local_drops));

    always @(negedge clk) if (rst_n && out_byte != 8'h00) got.push_back(out_byte);

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(input logic [7:0] t, input logic [7:0] l);
        @(negedge clk);
        thru_byte  = t;
        local_byte = l;
    endtask

    task automatic idle_n(input int n);
        repeat (n) drive(8'h00, 8'h00);
    endtask

    function automatic logic [7:0] pay(input int seed, input int i);
        return 8'h02 + 8'((seed + i) % 62);
    endfunction

    task automatic send_pkt(input bit src, input int len, input int seed);
        logic [7:0] b;
        for (int i = 0; i < len + 2; i++) begin
            b = (i == 0) ? ST : (i == len + 1) ? SP : pay(seed, i);
            exp.push_back(b);
            if (src) drive(8'h00, b); else drive(b, 8'h00);
        end
    endtask

    task automatic drain_check(input string req);
        idle_n(40);
        check(got.size() == exp.size(), req, got.size(), exp.size());
        if (got.size() == exp.size())
            for (int i = 0; i < exp.size(); i++)
                check(got[i] == exp[i], req, got[i], exp[i]);
        got.delete();
        exp.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int max_t, max_l;
        logic [7:0] p1, p2;
        max_t = 0; max_l = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(out_byte == 8'h00, "R1 out", out_byte, 0);
        check(thru_level == 0 && local_level == 0, "R1 level", thru_level + local_level, 0);
        check(thru_peak == 0 && local_peak == 0, "R1 peak", thru_peak + local_peak, 0);
        check(thru_drops == 0 && local_drops == 0, "R1 drops", thru_drops + local_drops, 0);

        // R3 vector table: each packet alone, forwarded intact
        for (int v = 0; v < NV; v++) begin
            send_pkt(VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            if (VEC[v][16]) max_l = (int'(VEC[v][15:8]) + 2 > max_l) ? int'(VEC[v][15:8]) + 2 : max_l;
            else            max_t = (int'(VEC[v][15:8]) + 2 > max_t) ? int'(VEC[v][15:8]) + 2 : max_t;
            drain_check("R3 table");
        end
        // R11 peaks equal largest packet per queue
        check(thru_peak == LW'(max_t), "R11 thru peak", thru_peak, max_t);
        check(local_peak == LW'(max_l), "R11 local peak", local_peak, max_l);

        // R2 stray bytes outside a packet and IDLE inside one
        drive(8'h22, 8'h00); drive(SP, 8'h00); drive(8'h33, 8'h00); idle_n(3);
        check(thru_level == 0, "R2 stray level", thru_level, 0);
        check(got.size() == 0, "R2 stray output", got.size(), 0);
        drive(ST, 0); drive(8'h05, 0); drive(8'h00, 0); drive(8'h00, 0); drive(8'h06, 0);
        idle_n(1);
        check(thru_level == 3, "R2 idle not stored", thru_level, 3);
        drive(SP, 0);
        exp.push_back(ST); exp.push_back(8'h05); exp.push_back(8'h06); exp.push_back(SP);
        drain_check("R2 idle removed");

        // R4 partial packet not served
        drive(ST, 0); drive(8'h07, 0); drive(8'h08, 0); drive(8'h09, 0); idle_n(12);
        check(got.size() == 0, "R4 no output", got.size(), 0);
        check(thru_level == 4, "R4 level", thru_level, 4);
        check(out_byte == 8'h00, "R8 idle output", out_byte, 0);
        drive(SP, 0);
        exp.push_back(ST); exp.push_back(8'h07); exp.push_back(8'h08);
        exp.push_back(8'h09); exp.push_back(SP);
        drain_check("R4 served after STOP");

        // R3 restart: START inside an open packet drops the partial
        drive(ST, 0); drive(8'h0a, 0); drive(ST, 0); drive(8'h0b, 0); drive(SP, 0);
        exp.push_back(ST); exp.push_back(8'h0b); exp.push_back(SP);
        drain_check("R3 restart");

        // R5 larger occupancy wins: local 8 bytes vs thru 3, STOPs aligned
        drive(0, ST); drive(0, 8'h11); drive(0, 8'h12); drive(0, 8'h13); drive(0, 8'h14);
        drive(ST, 8'h15); drive(8'h21, 8'h16); drive(SP, SP);
        exp = '{ST, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, SP, ST, 8'h21, SP};
        drain_check("R5 larger first");

        // R6 tie goes to thru
        p1 = 8'h31; p2 = 8'h32;
        drive(ST, ST); drive(p1, p2); drive(p1, p2); drive(SP, SP);
        exp = '{ST, p1, p1, SP, ST, p2, p2, SP};
        drain_check("R6 tie thru first");

        // R7 no interleave: thru completes while local drains
        send_pkt(1'b1, 20, 7);
        send_pkt(1'b0, 1, 9);
        drain_check("R7 no interleave");
        // R8 output idle afterwards
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_byte == 8'h00, "R8 idle", out_byte, 0);
        end

        // R9 overflow on local
        drive(0, ST);
        for (int i = 0; i < DEPTH - 1; i++) drive(0, pay(1, i));
        idle_n(1);
        check(local_level == LW'(DEPTH), "R9 full level", local_level, DEPTH);
        check(local_drops == 0, "R9 no drop yet", local_drops, 0);
        drive(0, 8'h05); idle_n(1);
        check(local_level == 0, "R9 partial removed", local_level, 0);
        check(local_drops == 1, "R9 drop count", local_drops, 1);
        check(local_peak == LW'(DEPTH), "R11 peak full", local_peak, DEPTH);
        for (int i = 0; i < 5; i++) drive(0, 8'h06);
        drive(0, SP); idle_n(10);
        check(local_level == 0, "R9 tail skipped", local_level, 0);
        check(local_drops == 1, "R9 tail not counted", local_drops, 1);
        check(got.size() == 0, "R9 no fragment", got.size(), 0);
        send_pkt(1'b1, 4, 12);
        drain_check("R9 recovers");

        // R10 saturation after 9 overflows total
        for (int k = 0; k < 8; k++) begin
            drive(0, ST);
            for (int i = 0; i < DEPTH; i++) drive(0, pay(2, i));
            drive(0, SP);
            if (k == 5) begin
                idle_n(1);
                check(local_drops == 7, "R10 reaches max", local_drops, 7);
            end
        end
        idle_n(5);
        check(local_drops == 7, "R10 saturated", local_drops, 7);
        check(thru_drops == 0, "R9 thru untouched", thru_drops, 0);
        check(got.size() == 0, "R9 overflow no output", got.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule